// File: doc/BRIEF.md
# OTG Host Role Handoff Controller (A-device side)

This block sequences the A-device half of a host-role swap on a dual-role USB link. Out of reset it holds the host role. Once the attached B-device reports that it can take the host role, the controller asks the transfer engine to send the set-feature request that enables the handoff. When that request has completed, it asks for the bus to be suspended. During the suspend it watches the D+ line. A B-device that wants to become host lets go of its D+ pull-up. When D+ stays low for a filtered number of clocks, the controller drops to the peripheral role. If no release comes within a programmable number of millisecond ticks, it asks for a resume and remains host. Whenever the session ends, the controller goes to idle. A new attach (D+ high with the session valid) makes it host again.

The inputs are plain control levels and one-cycle strobes. The outputs are a role level, the state code and three request strobes. Each request strobe lasts one cycle. Nothing flows as a data stream, so there is no valid/ready handshake and there is no back-pressure. The downstream engines must capture each request strobe in the cycle it is high.

Top module: `otg_handoff_ctrl`

## Requirements
- R1: After reset the state code is 1 (host), `role_host` is 1 and all three request strobes are 0.
- R2: In the host state, a high `b_hnp_capable` moves the controller to state 2 (enable pending) at the next clock. `req_set_feature` is high for exactly that first cycle, and no two request strobes are ever high together.
- R3: While `b_hnp_capable` stays low, the controller stays in state 1 with role 1 and issues no request, even if D+ goes low.
- R4: In state 2, `cmd_done` moves the controller to state 3 (suspended), with `req_suspend` high for that first cycle. A low D+ or `ms_tick` pulses in state 2 have no effect.
- R5: In state 3, if `dp_high` is sampled low at FILTER_CYC consecutive clock edges, the controller enters state 4 (peripheral) with role 0 at the following edge. Any shorter low run leaves it in state 3.
- R6: In state 3, when the count of sampled `ms_tick` pulses reaches `timeout_ms`, the controller enters state 5 (host, no retry) at the next edge, with `req_resume` high for that cycle and role 1. Fewer pulses leave it in state 3.
- R7: A high `session_end` sampled at any edge puts the controller in state 0 (idle) with role 1. This takes priority over every other transition.
- R8: In state 0, the controller moves to state 1 at the edge where `session_end` is low and `dp_high` is high.
- R9: `role_host` changes only together with a state change. States 4 and 5 persist, whatever D+ or `ms_tick` do, until `session_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| b_hnp_capable | input | 1 | Attached B-device advertises host negotiation |
| cmd_done | input | 1 | Strobe: handoff-enable request completed |
| dp_high | input | 1 | D+ line sampled high (pull-up present), already synchronous |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| session_end | input | 1 | Session has ended (VBUS dropped) |
| timeout_ms | input | TIMEOUT_W | Suspend timeout in millisecond ticks |
| role_host | output | 1 | 1 = host role, 0 = peripheral role |
| hs_state | output | 3 | State code: 0 idle, 1 host, 2 enable pending, 3 suspended, 4 peripheral, 5 host hold |
| req_set_feature | output | 1 | Strobe: send the handoff-enable set-feature request |
| req_suspend | output | 1 | Strobe: suspend the bus |
| req_resume | output | 1 | Strobe: resume the bus after the timeout |

## Verification
The D+ release is swept over low runs from one clock up to one beyond the filter length. This shows whether the filter boundary sits at exactly FILTER_CYC edges and whether a short glitch is rejected. The timeout is swept from 1 to 4 ticks, with a check after every tick, which places the expiry on the exact tick. D+ drops and tick pulses are applied in the host, enable-pending, peripheral and hold states, to show that the release detector and the timer act only during suspend. The session end is applied from each of the five active states, followed by a re-attach, to confirm that idle takes priority and that a new session can start.

// File: rtl/otg_handoff_pkg.sv
package otg_handoff_pkg;
  typedef enum logic [2:0] {
    HS_IDLE   = 3'd0,
    HS_HOST   = 3'd1,
    HS_FEAT   = 3'd2,
    HS_SUSP   = 3'd3,
    HS_PERIPH = 3'd4,
    HS_HOLD   = 3'd5
  } hs_state_e;
endpackage

// File: rtl/otg_release_filter.sv
module otg_release_filter #(
  parameter int FILTER_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dp_high,
  output logic released
);
  localparam int CW = $clog2(FILTER_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(FILTER_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || dp_high) low_cnt <= '0;
    else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
  end

  assign released = (low_cnt == FULL);

  // a release can only be reported after a low sample taken while enabled
  AST_REL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    released |-> (!$past(dp_high) && $past(en))); // R5
endmodule

// File: rtl/otg_suspend_timer.sv
module otg_suspend_timer #(
  parameter int TIMEOUT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 tick,
  input  logic [TIMEOUT_W-1:0] limit,
  output logic                 expired
);
  logic [TIMEOUT_W-1:0] ms_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) ms_cnt <= '0;
    else if (tick && (ms_cnt != '1)) ms_cnt <= ms_cnt + 1'b1;
  end

  assign expired = en && (ms_cnt >= limit);

  // the count only advances on a sampled tick
  AST_TIMER_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && (ms_cnt != $past(ms_cnt))) |-> $past(tick)); // R6
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
  import otg_handoff_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      b_hnp_capable,
  input  logic      cmd_done,
  input  logic      dp_high,
  input  logic      session_end,
  input  logic      released,
  input  logic      expired,
  output hs_state_e state_q,
  output logic      susp_active,
  output logic      role_host,
  output logic      req_set_feature,
  output logic      req_suspend,
  output logic      req_resume
);
  hs_state_e nxt;

  always_comb begin
    nxt = state_q;
    case (state_q)
      HS_IDLE:   if (dp_high) nxt = HS_HOST;
      HS_HOST:   if (b_hnp_capable) nxt = HS_FEAT;
      HS_FEAT:   if (cmd_done) nxt = HS_SUSP;
      HS_SUSP: begin
        if (released) nxt = HS_PERIPH;
        else if (expired) nxt = HS_HOLD;
      end
      HS_PERIPH: nxt = HS_PERIPH;
      HS_HOLD:   nxt = HS_HOLD;
      default:   nxt = HS_IDLE;
    endcase
    if (session_end) nxt = HS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q         <= HS_HOST;
      role_host       <= 1'b1;
      req_set_feature <= 1'b0;
      req_suspend     <= 1'b0;
      req_resume      <= 1'b0;
    end else begin
      state_q         <= nxt;
      role_host       <= (nxt != HS_PERIPH);
      req_set_feature <= (state_q == HS_HOST) && (nxt == HS_FEAT);
      req_suspend     <= (state_q == HS_FEAT) && (nxt == HS_SUSP);
      req_resume      <= (state_q == HS_SUSP) && (nxt == HS_HOLD);
    end
  end

  assign susp_active = (state_q == HS_SUSP);

  AST_ROLE_WITH_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (role_host != $past(role_host)) |-> (state_q != $past(state_q))); // R9
  AST_PERIPH_FROM_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == HS_PERIPH) && ($past(state_q) != HS_PERIPH)) |-> ($past(state_q) == HS_SUSP)); // R5
  AST_FEAT_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_set_feature |-> $past(b_hnp_capable)); // R3
  AST_SESSION_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(session_end) |-> (state_q == HS_IDLE)); // R7
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_set_feature, req_suspend, req_resume})); // R2
endmodule

// File: rtl/otg_handoff_ctrl.sv
module otg_handoff_ctrl
  import otg_handoff_pkg::*;
#(
  parameter int FILTER_CYC = 4,
  parameter int TIMEOUT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 b_hnp_capable,
  input  logic                 cmd_done,
  input  logic                 dp_high,
  input  logic                 ms_tick,
  input  logic                 session_end,
  input  logic [TIMEOUT_W-1:0] timeout_ms,
  output logic                 role_host,
  output logic [2:0]           hs_state,
  output logic                 req_set_feature,
  output logic                 req_suspend,
  output logic                 req_resume
);
  hs_state_e state_q;
  logic      susp_active;
  logic      released;
  logic      expired;

  otg_release_filter #(.FILTER_CYC(FILTER_CYC)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (susp_active),
    .dp_high  (dp_high),
    .released (released)
  );

  otg_suspend_timer #(.TIMEOUT_W(TIMEOUT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (susp_active),
    .tick    (ms_tick),
    .limit   (timeout_ms),
    .expired (expired)
  );

  otg_role_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .b_hnp_capable   (b_hnp_capable),
    .cmd_done        (cmd_done),
    .dp_high         (dp_high),
    .session_end     (session_end),
    .released        (released),
    .expired         (expired),
    .state_q         (state_q),
    .susp_active     (susp_active),
    .role_host       (role_host),
    .req_set_feature (req_set_feature),
    .req_suspend     (req_suspend),
    .req_resume      (req_resume)
  );

  assign hs_state = state_q;

  AST_PERIPH_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_PERIPH) |-> !role_host); // R5
endmodule

// File: tb/otg_handoff_ctrl_test.sv
`timescale 1ns/1ps
module otg_handoff_ctrl_test;
  localparam int F  = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n, cap, done, dp, tick, send;
  logic [TW-1:0] tmo;
  logic role;
  logic [2:0] st;
  logic rq_f, rq_s, rq_r;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  otg_handoff_ctrl #(.FILTER_CYC(F), .TIMEOUT_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .b_hnp_capable(cap), .cmd_done(done),
    .dp_high(dp), .ms_tick(tick), .session_end(send), .timeout_ms(tmo),
    .role_host(role), .hs_state(st), .req_set_feature(rq_f),
    .req_suspend(rq_s), .req_resume(rq_r)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int t);
    @(negedge clk);
    rst_n = 1'b0; cap = 1'b0; done = 1'b0; dp = 1'b1; tick = 1'b0; send = 1'b0;
    tmo = TW'(t);
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic to_susp();
    cap = 1'b1; step(); cap = 1'b0;
    done = 1'b1; step(); done = 1'b0;
  endtask

  task automatic to_periph();
    to_susp();
    dp = 1'b0;
    repeat (F + 1) step();
    dp = 1'b1;
  endtask

  task automatic to_hold();
    to_susp();
    repeat (int'(tmo)) begin tick = 1'b1; step(); tick = 1'b0; step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(2);
    check("R1 state", st, 1);
    check("R1 role", role, 1);
    check("R1 strobes", {rq_f, rq_s, rq_r}, 0);

    // R3 no capability: D+ drop ignored, no requests
    dp = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step();
      check("R3 state", st, 1);
      check("R3 strobes", {rq_f, rq_s, rq_r}, 0);
    end
    dp = 1'b1;
    check("R3 role", role, 1);

    // R2 request issue, R4 enable pending ignores D+ and ticks
    cap = 1'b1; step(); cap = 1'b0;
    check("R2 state", st, 2);
    check("R2 strobe", {rq_f, rq_s, rq_r}, 3'b100);
    dp = 1'b0; tick = 1'b1;
    step();
    check("R2 strobe drop", rq_f, 0);
    repeat (8) step();
    dp = 1'b1; tick = 1'b0;
    check("R4 ignore", st, 2);
    done = 1'b1; step(); done = 1'b0;
    check("R4 state", st, 3);
    check("R4 strobe", {rq_f, rq_s, rq_r}, 3'b010);
    step();
    check("R4 strobe drop", rq_s, 0);

    // R5 low-run sweep over the filter boundary
    for (int len = 1; len <= F + 1; len++) begin
      do_reset(200);
      to_susp();
      dp = 1'b0;
      for (int k = 1; k <= len; k++) begin
        step();
        if (k <= F) check("R5 before filter", st, 3);
      end
      dp = 1'b1;
      step();
      check("R5 after run", st, (len >= F) ? 4 : 3);
      check("R5 role", role, (len >= F) ? 0 : 1);
    end

    // R6 timeout sweep
    for (int t = 1; t <= 4; t++) begin
      do_reset(t);
      to_susp();
      for (int k = 1; k <= t; k++) begin
        tick = 1'b1; step(); tick = 1'b0; step();
        check("R6 state", st, (k == t) ? 5 : 3);
        check("R6 resume strobe", rq_r, (k == t) ? 1 : 0);
      end
      check("R6 role", role, 1);
      step();
      check("R6 strobe drop", rq_r, 0);
    end

    // R9 persistence in peripheral and hold
    do_reset(2);
    to_periph();
    for (int i = 0; i < 6; i++) begin
      dp = i[0]; tick = 1'b1; step();
    end
    dp = 1'b1; tick = 1'b0;
    check("R9 periph state", st, 4);
    check("R9 periph role", role, 0);
    do_reset(2);
    to_hold();
    for (int i = 0; i < 6; i++) begin
      dp = 1'b0; tick = 1'b1; step();
    end
    dp = 1'b1; tick = 1'b0;
    check("R9 hold state", st, 5);
    check("R9 hold role", role, 1);

    // R7 session end from each active state, R8 re-attach
    for (int s = 1; s <= 5; s++) begin
      do_reset(2);
      case (s)
        2: begin cap = 1'b1; step(); cap = 1'b0; end
        3: to_susp();
        4: to_periph();
        5: to_hold();
        default: ;
      endcase
      check("R7 start state", st, s);
      send = 1'b1; cap = 1'b1; done = 1'b1; step();
      cap = 1'b0; done = 1'b0;
      check("R7 idle", st, 0);
      check("R7 role", role, 1);
      step();
      check("R8 hold idle", st, 0);
      dp = 1'b0; send = 1'b0; step();
      check("R8 no attach", st, 0);
      dp = 1'b1; step();
      check("R8 attach", st, 1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule